// File: doc/BRIEF.md
# E1 CRC-4 E-bit Handler

This block looks after the two E-bits of an E1 CRC-4 multiframe. On the transmit side it gives the E-bit values for frames 13 and 15 of each outgoing multiframe. An E-bit of 1 reports a good submultiframe and 0 reports a CRC failure. The values can come from two host control bits. In automatic mode they come instead from the CRC verdicts of the submultiframes received most recently. When the receiver is not in multiframe alignment, a single polarity bit drives both E-bits. The transmit values change only at a transmit multiframe boundary.

On the receive side, the block reads the first transmitted bit of each timeslot-0 byte in frames 13 and 15. It counts zeros there, because each zero is a CRC failure reported by the far end. The counter is 16 bits wide, counts only while in multiframe alignment, and stops at its maximum value. A read strobe copies the count into a snapshot register and restarts the count. The CRC check itself is done elsewhere and arrives here as a per-submultiframe verdict strobe.

Top module: `ebit_engine`

## Requirements
- R1: After reset, tx_e13 and tx_e15 are 1 and cnt_snap is 0.
- R2: tx_e13 and tx_e15 change only on the clock edge that samples tx_mf_start high, and are visible from the following cycle.
- R3: With sync_state 2'b10 (multiframe aligned) and auto_mode 0, a boundary loads tx_e13 from host_e13 and tx_e15 from host_e15 as sampled at that edge.
- R4: With sync_state 2'b10 and auto_mode 1, a boundary loads tx_e13 with the inverted CRC error flag of submultiframe I and tx_e15 with that of submultiframe II (smf_sel 0 is I, 1 is II).
- R5: With any sync_state other than 2'b10 (2'b00 doubleframe, 2'b01 multiframe unaligned, 2'b11 unused), a boundary loads both outputs with ebit_pol, whatever auto_mode and the host bits are.
- R6: With sync_state 2'b10, ebit_pol has no effect on the transmitted E-bits.
- R7: A received byte (rx_ts0_valid high) with rx_frame_idx 13 or 15, sync_state 2'b10 and bit 7 of rx_ts0_byte (the first transmitted bit) at 0 adds one to the count.
- R8: Bytes from other frames, bytes with bit 7 at 1, and bytes received while sync_state is not 2'b10 leave the count unchanged.
- R9: The count stops at 65535 and does not wrap.
- R10: A cnt_rd pulse copies the count into cnt_snap and clears the count. A qualifying byte in the same cycle is counted in the new period, so the count becomes 1.
- R11: The automatic-mode verdicts move to the transmit side only when submultiframe II completes. A submultiframe I verdict on its own does not change what the next boundary sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_state | input | 2 | 00 doubleframe, 01 multiframe unaligned, 10 multiframe aligned, 11 unused |
| auto_mode | input | 1 | 1 sends the received CRC verdicts as E-bits |
| ebit_pol | input | 1 | E-bit value used outside multiframe alignment |
| host_e13 | input | 1 | Host value for the frame 13 E-bit |
| host_e15 | input | 1 | Host value for the frame 15 E-bit |
| smf_done | input | 1 | Strobe: a received submultiframe CRC check has finished |
| smf_sel | input | 1 | Which submultiframe finished: 0 is I, 1 is II |
| smf_crc_err | input | 1 | 1 when that submultiframe failed its CRC |
| tx_mf_start | input | 1 | Strobe: transmit multiframe boundary |
| tx_e13 | output | 1 | E-bit for outgoing frame 13 |
| tx_e15 | output | 1 | E-bit for outgoing frame 15 |
| rx_ts0_valid | input | 1 | Strobe: rx_ts0_byte and rx_frame_idx are valid |
| rx_frame_idx | input | 4 | Frame number within the received multiframe, 0 to 15 |
| rx_ts0_byte | input | 8 | Received timeslot-0 byte, bit 7 transmitted first |
| cnt_rd | input | 1 | Strobe: copy the count into the snapshot and clear the count |
| cnt_snap | output | 16 | Count captured by the last cnt_rd |

## Verification
The bench checks that a change to a host bit between boundaries does not reach the line. It checks that a submultiframe I verdict without its partner II verdict leaves the automatic output unchanged, where a design that copied each verdict as it arrived would send a half-updated pair. Rows with every sync_state code confirm that outside alignment the polarity bit overrides both the host bits and the CRC verdicts, and that inside alignment it is ignored. On the counter side, the bench drives a read in the same cycle as a zero E-bit, where a design that dropped that event would report 0 on the next read instead of 1. It also runs the count to its ceiling, where a wrapping counter would report a small number.

// File: rtl/ebit_pkg.sv
// Package: shared encodings for the E-bit handler.
// Assumes the framer reports alignment as one of the codes below.
package ebit_pkg;
    typedef enum logic [1:0] {
        SYNC_DOUBLE   = 2'b00,
        SYNC_MF_HUNT  = 2'b01,
        SYNC_MF_ALIGN = 2'b10,
        SYNC_UNUSED   = 2'b11
    } sync_code_e;

    localparam int unsigned NUM_EBITS = 2;  // lane 0: frame 13, lane 1: frame 15
endpackage

// File: rtl/ebit_rx_status.sv
// Module: ebit_rx_status
// Holds the CRC verdicts of received submultiframes as E-bit values
// (1 = good). The verdict of submultiframe I is parked until
// submultiframe II completes; then both are published together.
// Assumes at most one smf_done strobe per cycle.
module ebit_rx_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smf_done,
    input  logic       smf_sel,
    input  logic       smf_crc_err,
    output logic [1:0] stat_bits
);
    logic parked_first;

    // Park the first verdict; publish the pair when the second arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parked_first <= 1'b1;
            stat_bits    <= 2'b11;
        end else if (smf_done) begin
            if (!smf_sel) begin
                parked_first <= ~smf_crc_err;
            end else begin
                stat_bits <= {~smf_crc_err, parked_first};
            end
        end
    end
endmodule

// File: rtl/ebit_tx_select.sv
// Module: ebit_tx_select
// Chooses the transmitted E-bit per lane and registers it at a
// transmit multiframe boundary. Aligned: host bits or received
// verdicts, depending on auto_mode. Not aligned: polarity bit.
// Assumes mf_start is a one-cycle strobe.
module ebit_tx_select #(
    parameter int unsigned LANES = ebit_pkg::NUM_EBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mf_start,
    input  logic             aligned,
    input  logic             auto_mode,
    input  logic             pol,
    input  logic [LANES-1:0] host_bits,
    input  logic [LANES-1:0] stat_bits,
    output logic [LANES-1:0] ebits
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic next_bit;

            // Pick the source for this lane.
            always_comb begin
                if (!aligned)       next_bit = pol;
                else if (auto_mode) next_bit = stat_bits[g];
                else                next_bit = host_bits[g];
            end

            // Load the lane only at a multiframe boundary.
            always_ff @(posedge clk) begin
                if (!rst_n)        ebits[g] <= 1'b1;
                else if (mf_start) ebits[g] <= next_bit;
            end
        end
    endgenerate
endmodule

// File: rtl/ebit_err_counter.sv
// Module: ebit_err_counter
// Counts zero E-bits in the two E-bit frames while aligned, stops at
// the maximum value, and on rd copies the count to snap and restarts
// it. An event in the read cycle opens the new period with 1.
// Assumes rx_valid marks one timeslot-0 byte per strobe.
module ebit_err_counter #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned FRAME_W  = 4,
    parameter int unsigned FRAME_A  = 13,
    parameter int unsigned FRAME_B  = 15,
    parameter int unsigned EBIT_POS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aligned,
    input  logic               rx_valid,
    input  logic [FRAME_W-1:0] rx_idx,
    input  logic [7:0]         rx_byte,
    input  logic               rd,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   snap
);
    localparam logic [CNT_W-1:0]   CNT_MAX = {CNT_W{1'b1}};
    localparam logic [FRAME_W-1:0] IDX_A   = FRAME_W'(FRAME_A);
    localparam logic [FRAME_W-1:0] IDX_B   = FRAME_W'(FRAME_B);

    logic is_eframe;
    logic hit;

    // Qualify a received zero E-bit.
    always_comb begin
        is_eframe = (rx_idx == IDX_A) || (rx_idx == IDX_B);
        hit       = rx_valid && aligned && is_eframe && !rx_byte[EBIT_POS];
    end

    // Saturating count with latch-and-clear read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            snap  <= '0;
        end else if (rd) begin
            snap  <= count;
            count <= hit ? CNT_W'(1) : '0;
        end else if (hit && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ebit_engine.sv
// Module: ebit_engine (top)
// E1 CRC-4 E-bit handler: transmit E-bit selection for frames 13/15
// and receive E-bit error counting. Assumes strobes are one cycle long
// and that CRC verdicts come from an external checker.
module ebit_engine #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned FRAME_W  = 4,
    parameter int unsigned FRAME_A  = 13,
    parameter int unsigned FRAME_B  = 15,
    parameter int unsigned EBIT_POS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sync_state,
    input  logic               auto_mode,
    input  logic               ebit_pol,
    input  logic               host_e13,
    input  logic               host_e15,
    input  logic               smf_done,
    input  logic               smf_sel,
    input  logic               smf_crc_err,
    input  logic               tx_mf_start,
    output logic               tx_e13,
    output logic               tx_e15,
    input  logic               rx_ts0_valid,
    input  logic [FRAME_W-1:0] rx_frame_idx,
    input  logic [7:0]         rx_ts0_byte,
    input  logic               cnt_rd,
    output logic [CNT_W-1:0]   cnt_snap
);
    import ebit_pkg::*;

    logic                 aligned;
    logic [NUM_EBITS-1:0] stat_bits;
    logic [NUM_EBITS-1:0] ebits;
    logic [CNT_W-1:0]     err_count;

    // Decode the alignment code.
    always_comb aligned = (sync_code_e'(sync_state) == SYNC_MF_ALIGN);

    ebit_rx_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .smf_done    (smf_done),
        .smf_sel     (smf_sel),
        .smf_crc_err (smf_crc_err),
        .stat_bits   (stat_bits)
    );

    ebit_tx_select #(.LANES(NUM_EBITS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mf_start  (tx_mf_start),
        .aligned   (aligned),
        .auto_mode (auto_mode),
        .pol       (ebit_pol),
        .host_bits ({host_e15, host_e13}),
        .stat_bits (stat_bits),
        .ebits     (ebits)
    );

    ebit_err_counter #(
        .CNT_W    (CNT_W),
        .FRAME_W  (FRAME_W),
        .FRAME_A  (FRAME_A),
        .FRAME_B  (FRAME_B),
        .EBIT_POS (EBIT_POS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .aligned  (aligned),
        .rx_valid (rx_ts0_valid),
        .rx_idx   (rx_frame_idx),
        .rx_byte  (rx_ts0_byte),
        .rd       (cnt_rd),
        .count    (err_count),
        .snap     (cnt_snap)
    );

    // Map lanes to output pins.
    always_comb begin
        tx_e13 = ebits[0];
        tx_e15 = ebits[1];
    end
endmodule

// File: rtl/ebit_engine_chk.sv
// Module: ebit_engine_chk
// Property checker for ebit_engine, attached by bind below.
module ebit_engine_chk #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned FRAME_W  = 4,
    parameter int unsigned FRAME_A  = 13,
    parameter int unsigned FRAME_B  = 15,
    parameter int unsigned EBIT_POS = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         sync_state,
    input logic               auto_mode,
    input logic               ebit_pol,
    input logic               host_e13,
    input logic               host_e15,
    input logic               tx_mf_start,
    input logic               tx_e13,
    input logic               tx_e15,
    input logic               rx_ts0_valid,
    input logic [FRAME_W-1:0] rx_frame_idx,
    input logic [7:0]         rx_ts0_byte,
    input logic               cnt_rd,
    input logic [CNT_W-1:0]   err_count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic in_al;
    logic zero_seen;
    always_comb begin
        in_al     = (sync_state == 2'b10);
        zero_seen = rx_ts0_valid && in_al && !rx_ts0_byte[EBIT_POS] &&
                    ((rx_frame_idx == FRAME_W'(FRAME_A)) || (rx_frame_idx == FRAME_W'(FRAME_B)));
    end

    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mf_start |=> ($stable(tx_e13) && $stable(tx_e15)));

    assert_host_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mf_start && in_al && !auto_mode) |=>
        (tx_e13 == $past(host_e13) && tx_e15 == $past(host_e15)));

    assert_pol_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mf_start && !in_al) |=>
        (tx_e13 == $past(ebit_pol) && tx_e15 == $past(ebit_pol)));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_seen && !cnt_rd && err_count != TOP) |=> (err_count == $past(err_count) + 1'b1));

    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_seen && !cnt_rd) |=> $stable(err_count));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == TOP && !cnt_rd) |=> (err_count == TOP));

    assert_read_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |=> (err_count <= CNT_W'(1)));
endmodule

bind ebit_engine ebit_engine_chk #(
    .CNT_W    (CNT_W),
    .FRAME_W  (FRAME_W),
    .FRAME_A  (FRAME_A),
    .FRAME_B  (FRAME_B),
    .EBIT_POS (EBIT_POS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_state   (sync_state),
    .auto_mode    (auto_mode),
    .ebit_pol     (ebit_pol),
    .host_e13     (host_e13),
    .host_e15     (host_e15),
    .tx_mf_start  (tx_mf_start),
    .tx_e13       (tx_e13),
    .tx_e15       (tx_e15),
    .rx_ts0_valid (rx_ts0_valid),
    .rx_frame_idx (rx_frame_idx),
    .rx_ts0_byte  (rx_ts0_byte),
    .cnt_rd       (cnt_rd),
    .err_count    (err_count)
);

// File: tb/ebit_engine_test.sv
`timescale 1ns/1ps
module ebit_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sync_state = 2'b00;
    logic        auto_mode = 1'b0, ebit_pol = 1'b0;
    logic        host_e13 = 1'b1, host_e15 = 1'b1;
    logic        smf_done = 1'b0, smf_sel = 1'b0, smf_crc_err = 1'b0;
    logic        tx_mf_start = 1'b0;
    logic        tx_e13, tx_e15;
    logic        rx_ts0_valid = 1'b0;
    logic [3:0]  rx_frame_idx = 4'd0;
    logic [7:0]  rx_ts0_byte = 8'hFF;
    logic        cnt_rd = 1'b0;
    logic [15:0] cnt_snap;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ebit_engine uut (.*);

    // Vector: [9:8] sync, [7] auto, [6] pol, [5] h13, [4] h15,
    //         [3] err I, [2] err II, [1] exp e13, [0] exp e15
    localparam int NV = 10;
    localparam logic [9:0] VEC [NV] = '{
        10'b10_0_0_1_0_0_0_1_0,  // R3
        10'b10_0_1_0_1_1_1_0_1,  // R3, R6
        10'b10_1_0_0_0_1_0_0_1,  // R4
        10'b10_1_1_1_1_0_1_1_0,  // R4, R6
        10'b00_1_1_0_0_1_1_1_1,  // R5
        10'b00_0_0_1_1_0_0_0_0,  // R5
        10'b01_1_0_1_1_0_0_0_0,  // R5
        10'b01_0_1_0_0_1_1_1_1,  // R5
        10'b10_1_0_0_0_0_0_1_1,  // R4
        10'b11_0_1_0_0_0_0_1_1   // R5
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic smf(input logic sel, input logic err);
        @(negedge clk); smf_done = 1'b1; smf_sel = sel; smf_crc_err = err;
        @(negedge clk); smf_done = 1'b0;
    endtask

    task automatic boundary();
        @(negedge clk); tx_mf_start = 1'b1;
        @(negedge clk); tx_mf_start = 1'b0;
    endtask

    task automatic rx(input logic [3:0] idx, input logic [7:0] b);
        @(negedge clk); rx_ts0_valid = 1'b1; rx_frame_idx = idx; rx_ts0_byte = b;
        @(negedge clk); rx_ts0_valid = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); cnt_rd = 1'b1;
        @(negedge clk); cnt_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 e13 reset", 16'(tx_e13), 16'd1);
        check("R1 e15 reset", 16'(tx_e15), 16'd1);
        check("R1 snap reset", cnt_snap, 16'd0);

        // Table walk: transmit selection.
        for (int i = 0; i < NV; i++) begin
            string tag;
            sync_state = VEC[i][9:8];
            auto_mode  = VEC[i][7];
            ebit_pol   = VEC[i][6];
            host_e13   = VEC[i][5];
            host_e15   = VEC[i][4];
            smf(1'b0, VEC[i][3]);
            smf(1'b1, VEC[i][2]);
            boundary();
            tag = (VEC[i][9:8] != 2'b10) ? "R5" : (VEC[i][7] ? "R4/R6" : "R3/R6");
            check($sformatf("%s row%0d e13", tag, i), 16'(tx_e13), 16'(VEC[i][1]));
            check($sformatf("%s row%0d e15", tag, i), 16'(tx_e15), 16'(VEC[i][0]));
        end

        // R2: host change without boundary is held back.
        sync_state = 2'b10; auto_mode = 1'b0; host_e13 = 1'b1; host_e15 = 1'b1;
        boundary();
        host_e13 = 1'b0; host_e15 = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 e13 held", 16'(tx_e13), 16'd1);
        check("R2 e15 held", 16'(tx_e15), 16'd1);
        boundary();
        check("R3 e13 loaded", 16'(tx_e13), 16'd0);
        check("R3 e15 loaded", 16'(tx_e15), 16'd0);

        // R11: submultiframe I alone does not publish.
        auto_mode = 1'b1;
        smf(1'b0, 1'b0); smf(1'b1, 1'b0);
        boundary();
        check("R11 base e13", 16'(tx_e13), 16'd1);
        smf(1'b0, 1'b1);
        boundary();
        check("R11 half pair e13", 16'(tx_e13), 16'd1);
        check("R11 half pair e15", 16'(tx_e15), 16'd1);
        smf(1'b1, 1'b0);
        boundary();
        check("R11 full pair e13", 16'(tx_e13), 16'd0);
        check("R11 full pair e15", 16'(tx_e15), 16'd1);

        // R7 / R8: counting.
        sync_state = 2'b10;
        rd_pulse();
        for (int f = 0; f < 16; f++) rx(4'(f), 8'h00);           // 2 hits
        rx(4'd13, 8'h80); rx(4'd15, 8'h7F);                      // 1 hit
        rx(4'd12, 8'h00); rx(4'd14, 8'h00);                      // none
        sync_state = 2'b01; rx(4'd13, 8'h00);                    // none
        sync_state = 2'b00; rx(4'd15, 8'h00);                    // none
        sync_state = 2'b10;
        rd_pulse();
        check("R7/R8 count", cnt_snap, 16'd3);
        rd_pulse();
        check("R10 cleared after read", cnt_snap, 16'd0);

        // R10: event coincident with read.
        rx(4'd13, 8'h00); rx(4'd15, 8'h00); rx(4'd13, 8'h00);
        @(negedge clk);
        rx_ts0_valid = 1'b1; rx_frame_idx = 4'd15; rx_ts0_byte = 8'h00; cnt_rd = 1'b1;
        @(negedge clk);
        rx_ts0_valid = 1'b0; cnt_rd = 1'b0;
        check("R10 snap before restart", cnt_snap, 16'd3);
        rd_pulse();
        check("R10 coincident event kept", cnt_snap, 16'd1);

        // R9: saturation.
        rd_pulse();
        @(negedge clk);
        rx_ts0_valid = 1'b1; rx_frame_idx = 4'd13; rx_ts0_byte = 8'h00;
        repeat (65540) @(negedge clk);
        rx_ts0_valid = 1'b0;
        rd_pulse();
        check("R9 saturated", cnt_snap, 16'hFFFF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1-flow actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule